// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets a host on a two-wire I2C bus read and write a bank of 8-bit configuration registers. It answers to one fixed 7-bit device address. The bus lines are open-drain: the block watches SCL and SDA as plain inputs, and it pulls SDA low by raising an output-enable. The register bank is outside the block. The block presents a register address, a write strobe with write data, and takes back the read data for the addressed register through a combinational read port.

A write transfer carries a subaddress byte and then any number of data bytes. Each data byte lands in the register after the previous one. A read transfer first sets the subaddress with a short write, then issues a repeated START with the read address. The slave then returns successive registers until the host declines a byte. Both lines are oversampled by the system clock through a synchronizer, so SCL must stay well below the system clock rate.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte equal to 0x88 (device address 1000100, bit 0 = 0, write) or 0x89 (bit 0 = 1, read). It acknowledges by asserting `sda_oe` (SDA pulled low) through the ninth SCL clock of that byte.
- R2: When an address byte does not match, the slave does not acknowledge it. It also does not acknowledge or act on any later byte until the next START.
- R3: In a write transfer, the byte after the address is the subaddress and is acknowledged. Each later byte is acknowledged and produces exactly one single-cycle `reg_we` pulse, with `reg_wdata` equal to the byte and `reg_addr` equal to the current pointer.
- R4: The register pointer advances by one, modulo 2^ADDR_W, after every data byte, whether written or read. `reg_addr` is steady while `reg_we` is high.
- R5: After a repeated START with 0x89, the slave drives the register at the pointer most-significant bit first. It drives one bit for each SCL clock and releases SDA in the ninth clock. When the host acknowledges (SDA low in the ninth clock), the slave sends the next register.
- R6: When the host does not acknowledge a read byte (SDA high in the ninth clock), the slave stops driving SDA until the next START.
- R7: A STOP (SDA rising while SCL is high) at any bit position returns the slave to idle without a write. A START (SDA falling while SCL is high) at any bit position restarts address reception.
- R8: Data is sampled on the rising edge of SCL. The slave only begins pulling SDA low while SCL is low.
- R9: During and right after reset, `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | ADDR_W | Register pointer for read and write |
| reg_wdata | output | 8 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
A multi-byte write is followed by a multi-byte read of the same registers. This separates a correct auto-incrementing pointer from one that is stuck or skips, and shows whether bits come out in MSB-first order. A subaddress of all ones is used to expose pointer wrap. Wrong addresses for both read and write, with trailing bytes, show that a silent slave really stays silent. A STOP or a START cut into the middle of a data byte shows that a partial byte neither writes nor corrupts the next transfer.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
   localparam int BYTE_W   = 8;
   localparam int ACK_SLOT = BYTE_W;       // bit count at which the ninth clock begins
   localparam int FRAME_END = BYTE_W + 1;  // bit count after the ninth clock

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB,
      ST_WDATA,
      ST_RDATA
   } slv_state_t;
endpackage

// File: rtl/i2c_slv_line_mon.sv
module i2c_slv_line_mon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
   logic scl_s, scl_d, sda_d;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain <= '1;
               sda_chain <= '1;
            end else begin
               scl_chain[0] <= scl_raw;
               sda_chain[0] <= sda_raw;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain <= '1;
               sda_chain <= '1;
            end else begin
               scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_raw};
               sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_raw};
            end
         end
      end
   endgenerate

   assign scl_s = scl_chain[SYNC_STAGES-1];
   assign sda_s = sda_chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slv_shreg.sv
module i2c_slv_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   input  logic         fill,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load_en)  q <= load_val;
      else if (shift_en) q <= {q[W-2:0], fill};
   end
endmodule

// File: rtl/i2c_slv_ptr.sv
module i2c_slv_ptr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         inc_en,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (load_en) q <= load_val;
      else if (inc_en)  q <= q + W'(1);
   end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
   import i2c_slv_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h44,
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata
);
   localparam int CNT_W = $clog2(FRAME_END + 1);
   localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(ACK_SLOT);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_END);

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr_w
         $error("ADDR_W must lie between 1 and 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_slv_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   slv_state_t state_q, state_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic rw_q, rw_n, mack_q, mack_n, oe_q, oe_n, we_q, we_n;
   logic [7:0] wdata_q, wdata_n;
   logic sh_load, sh_shift, ptr_load, ptr_inc;
   logic [BYTE_W-1:0] sh_q;
   logic [ADDR_W-1:0] ptr_q;

   i2c_slv_shreg #(.W(BYTE_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load_en(sh_load), .load_val(reg_rdata),
      .shift_en(sh_shift), .fill(sda_s), .q(sh_q)
   );

   i2c_slv_ptr #(.W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_en(ptr_load), .load_val(sh_q[ADDR_W-1:0]),
      .inc_en(ptr_inc), .q(ptr_q)
   );

   always_comb begin
      state_n  = state_q;
      cnt_n    = cnt_q;
      rw_n     = rw_q;
      mack_n   = mack_q;
      oe_n     = oe_q;
      we_n     = 1'b0;
      wdata_n  = wdata_q;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      ptr_load = 1'b0;
      ptr_inc  = 1'b0;
      if (stop_det) begin
         state_n = ST_IDLE;
         oe_n    = 1'b0;
         cnt_n   = '0;
      end else if (start_det) begin
         state_n = ST_ADDR;
         oe_n    = 1'b0;
         cnt_n   = '0;
      end else if (state_q != ST_IDLE) begin
         if (scl_rise) begin
            if (cnt_q < CNT_ACK) begin
               if (state_q != ST_RDATA) sh_shift = 1'b1;
            end else if (state_q == ST_RDATA) begin
               mack_n = ~sda_s;
            end
            cnt_n = cnt_q + CNT_W'(1);
         end else if (scl_fall) begin
            if (cnt_q == CNT_ACK) begin
               case (state_q)
                  ST_ADDR: begin
                     if (sh_q[7:1] == DEV_ADDR) begin
                        oe_n = 1'b1;
                        rw_n = sh_q[0];
                     end else begin
                        state_n = ST_IDLE;
                     end
                  end
                  ST_SUB: begin
                     ptr_load = 1'b1;
                     oe_n     = 1'b1;
                  end
                  ST_WDATA: begin
                     we_n    = 1'b1;
                     wdata_n = sh_q;
                     oe_n    = 1'b1;
                  end
                  default: oe_n = 1'b0;
               endcase
            end else if (cnt_q == CNT_END) begin
               cnt_n = '0;
               oe_n  = 1'b0;
               case (state_q)
                  ST_ADDR: begin
                     if (rw_q) begin
                        state_n = ST_RDATA;
                        sh_load = 1'b1;
                        ptr_inc = 1'b1;
                        oe_n    = ~reg_rdata[7];
                     end else begin
                        state_n = ST_SUB;
                     end
                  end
                  ST_SUB:   state_n = ST_WDATA;
                  ST_WDATA: ptr_inc = 1'b1;
                  default: begin
                     if (mack_q) begin
                        sh_load = 1'b1;
                        ptr_inc = 1'b1;
                        oe_n    = ~reg_rdata[7];
                     end else begin
                        state_n = ST_IDLE;
                     end
                  end
               endcase
            end else if (state_q == ST_RDATA && cnt_q != '0) begin
               sh_shift = 1'b1;
               oe_n     = ~sh_q[6];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         oe_q    <= 1'b0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
         rw_q    <= rw_n;
         mack_q  <= mack_n;
         oe_q    <= oe_n;
         we_q    <= we_n;
         wdata_q <= wdata_n;
      end
   end

   assign sda_oe    = oe_q;
   assign reg_we    = we_q;
   assign reg_wdata = wdata_q;
   assign reg_addr  = ptr_q;
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr
);
   assert_oe_rise_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   assert_we_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> sda_oe);

   assert_we_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !scl_i);

   assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $stable(reg_addr));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
   localparam int CLK_PERIOD = 10;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, reg_we;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic sda_bus;
   logic [7:0] bank [256];
   logic [15:0] wq [$];
   int n_chk = 0, n_bad = 0;
   int mptr = 0;
   bit wd_hit = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_bus   = sda_m & ~sda_oe;
   assign reg_rdata = bank[reg_addr];

   i2c_reg_slave i_i2c_reg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model of the register bank and expected write stream, compared every clock
   always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (wq.size() == 0) chk(0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
         else begin
            logic [15:0] e;
            e = wq.pop_front();
            chk({reg_addr, reg_wdata} == e, "R3/R4 write addr+data", {reg_addr, reg_wdata}, e);
         end
      end
   end

   task automatic hw();
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; hw();
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; hw(); scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      b = sda_bus;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0; hw();
   endtask

   task automatic send_byte(input logic [7:0] d, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input bit give_ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(!give_ack);
   endtask

   task automatic wr_txn(input logic [7:0] sub, input logic [7:0] d0, input int n);
      bit ack;
      bus_start();
      send_byte(8'h88, ack); chk(ack, "R1 write address ack", ack, 1);
      send_byte(sub, ack);   chk(ack, "R3 subaddress ack", ack, 1);
      mptr = sub;
      for (int k = 0; k < n; k++) begin
         logic [7:0] d;
         d = d0 + 8'(k * 37);
         wq.push_back({8'(mptr), d});
         send_byte(d, ack); chk(ack, "R3 data ack", ack, 1);
         mptr = (mptr + 1) & 255;
      end
      bus_stop();
      hw();
      chk(wq.size() == 0, "R3 all writes issued", wq.size(), 0);
   endtask

   task automatic rd_txn(input logic [7:0] sub, input int n);
      bit ack, b;
      logic [7:0] d;
      bus_start();
      send_byte(8'h88, ack); chk(ack, "R1 write address ack", ack, 1);
      send_byte(sub, ack);   chk(ack, "R3 subaddress ack", ack, 1);
      mptr = sub;
      bus_start();
      send_byte(8'h89, ack); chk(ack, "R1 read address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(d, k != n - 1);
         chk(d == bank[mptr], "R5 read data", d, bank[mptr]);
         mptr = (mptr + 1) & 255;
      end
      chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
      get_bit(b);
      chk(b == 1'b1, "R6 silent after nack", b, 1);
      bus_stop();
   endtask

   initial begin
      for (int i = 0; i < 256; i++) bank[i] = 8'(i * 7 + 3);
      fork
         begin : main
            bit ack;
            logic [7:0] d;
            repeat (3) @(negedge clk);
            chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
            chk(reg_we == 1'b0, "R9 reset reg_we", reg_we, 0);
            rst_n = 1'b1;
            hw();
            chk(sda_oe == 1'b0, "R9 idle after reset", sda_oe, 0);

            // R3 R4: multi-byte write, then R5 R6 read back across the range
            wr_txn(8'h10, 8'hA5, 3);
            rd_txn(8'h10, 3);
            rd_txn(8'h0F, 1);

            // R4: pointer wrap
            wr_txn(8'hFF, 8'h5A, 2);
            rd_txn(8'hFE, 4);

            // R2: wrong write address followed by bytes
            bus_start();
            send_byte(8'h90, ack); chk(!ack, "R2 wrong address nack", ack, 0);
            send_byte(8'h20, ack); chk(!ack, "R2 later byte nack", ack, 0);
            send_byte(8'h11, ack); chk(!ack, "R2 later byte nack", ack, 0);
            bus_stop();
            // R2: wrong read address
            bus_start();
            send_byte(8'h8B, ack); chk(!ack, "R2 wrong read address nack", ack, 0);
            bus_stop();

            // R7: STOP inside a data byte writes nothing
            bus_start();
            send_byte(8'h88, ack); chk(ack, "R1 ack", ack, 1);
            send_byte(8'h20, ack); chk(ack, "R3 ack", ack, 1);
            put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
            bus_stop();
            hw();
            rd_txn(8'h20, 1);

            // R7: START inside a data byte restarts address reception
            bus_start();
            send_byte(8'h88, ack); chk(ack, "R1 ack", ack, 1);
            send_byte(8'h30, ack); chk(ack, "R3 ack", ack, 1);
            put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
            bus_start();
            send_byte(8'h88, ack); chk(ack, "R7 address after mid-byte start", ack, 1);
            send_byte(8'h31, ack); chk(ack, "R7 subaddress", ack, 1);
            wq.push_back({8'h31, 8'h77});
            send_byte(8'h77, ack); chk(ack, "R7 data ack", ack, 1);
            bus_stop();
            hw();
            chk(wq.size() == 0, "R7 write after restart", wq.size(), 0);
            rd_txn(8'h30, 2);
            hw();
         end
         begin : watchdog
            repeat (150000) @(posedge clk);
            wd_hit = 1;
         end
      join_any
      disable fork;
      if (wd_hit) chk(0, "watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule